// File: doc/BRIEF.md
# Dual-CPU Two-Stage Interrupt Gate

This block collects a set of level-sensitive device interrupt lines and presents them to two CPUs. Each source passes two gates before it reaches a CPU. The first gate is one enable bit per source, and both CPUs share it. The second gate is a mask bit per source that each CPU holds in its own bank. A CPU's interrupt output is high when at least one source is active, globally enabled and unmasked in that CPU's bank. The output is registered, so it follows its inputs one clock later.

Software uses a single-beat register bus that carries the ID of the requesting CPU as a sideband. The shared window holds the enable state, the raw input view and a pair of enable registers, one to set and one to clear. Each of these write registers takes a source number, so no read-modify-write is needed. A second window is aliased: it holds a mask-set and a mask-clear register and always resolves to the bank of the CPU making the access. Each source also has a control word whose low bits give its CPU affinity. Writing that word loads the source's mask bit in every bank at once. Reads are answered one cycle after the request.

Top module: `dual_irq_gate`

## Requirements
- R1: Output `cpu_irq[c]` equals the OR over all sources of (input AND global enable AND unmask bit of CPU c), taken from the values before the previous rising clock edge. Inputs are level-sensitive, so the output falls one cycle after the qualifying input falls.
- R2: While `rst_n` is low, all global enables are cleared, all mask bits of both banks are set to masked, `cpu_irq` is 0 and `bus_rvalid` is 0.
- R3: A write of source number n to offset 0x08 sets the global enable of source n. A write to 0x0C clears it. No other enable bit changes. A written value of N_SRC (32) or more changes nothing.
- R4: A write of source number n to offset 0x40 masks source n, and a write to 0x44 unmasks it. Only the bank selected by `bus_cpu` is affected. A value of N_SRC or more changes nothing.
- R5: Offset 0x80 + 4*n is the control word of source n. A write loads `bus_wdata[c]` as the unmask bit of source n for CPU c (bit 0 for CPU 0, bit 1 for CPU 1). A read returns those bits in [1:0], with all other bits zero.
- R6: A read of 0x00 returns the global enable vector (bit n is source n). A read of 0x04 returns the current raw input levels.
- R7: A read of 0x40 or 0x44 returns, for the requesting CPU only, the vector input AND enable AND unmask.
- R8: A read request is answered with `bus_rvalid` high and `bus_rdata` valid in the next cycle. A read of an unmapped offset returns 0. A write to 0x00, 0x04 or an unmapped offset changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | N_SRC | Level-sensitive device interrupt lines |
| bus_valid | input | 1 | Register access request, one beat |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_cpu | input | $clog2(N_CPU) | ID of the CPU making the access |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the request |
| cpu_irq | output | N_CPU | Interrupt output to each CPU |

## Verification
The hardest situation to reach is a source whose two mask bits differ between the CPUs while its global enable is switched and its input toggles. Only that mix shows whether the aliased window touched the wrong bank or whether an affinity write missed one bank. The stimulus first walks one source through this state on purpose. It then runs a long seeded random mix of enable, mask, affinity and read operations from both CPU IDs, using source numbers that include out-of-range values, with the inputs re-randomised after every operation. Both outputs and every read response are compared against a bench model.

// File: rtl/dig_pkg.sv
// Shared definitions for the dual-CPU interrupt gate: register offsets and
// the decoded operation / read-select encodings. Assumes byte offsets on a
// word-aligned register bus.
package dig_pkg;

    localparam int unsigned OFF_CTRL     = 32'h00;  // global enable vector (read)
    localparam int unsigned OFF_RAW      = 32'h04;  // raw input levels (read)
    localparam int unsigned OFF_EN_SET   = 32'h08;  // set one global enable
    localparam int unsigned OFF_EN_CLR   = 32'h0C;  // clear one global enable
    localparam int unsigned OFF_MSK_SET  = 32'h40;  // aliased: mask for own CPU
    localparam int unsigned OFF_MSK_CLR  = 32'h44;  // aliased: unmask for own CPU
    localparam int unsigned OFF_SRC_BASE = 32'h80;  // per-source control words

    typedef enum logic [2:0] {
        OP_NONE,
        OP_EN_SET,
        OP_EN_CLR,
        OP_MSK_SET,
        OP_MSK_CLR,
        OP_AFF_WR
    } dig_op_e;

    typedef enum logic [2:0] {
        RS_ZERO,
        RS_GEN,
        RS_RAW,
        RS_PEND,
        RS_AFF
    } dig_rsel_e;

endpackage

// File: rtl/dig_decode.sv
// Address decoder: turns one bus beat into a state-changing operation with a
// source index, and a read selector. Assumes SRC_W+2 <= ADDR_W and
// N_SRC <= DATA_W. Purely combinational.
module dig_decode
    import dig_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output dig_op_e                   wr_op,
    output logic [$clog2(N_SRC)-1:0]  wr_idx,
    output dig_rsel_e                 rd_sel,
    output logic [$clog2(N_SRC)-1:0]  rd_idx
);
    localparam int SRC_W = $clog2(N_SRC);

    logic [ADDR_W-1:0] aoff;
    logic              aff_hit;
    logic              val_ok;
    logic [SRC_W-1:0]  aidx;

    // Locate the per-source control word window and its index.
    assign aoff    = bus_addr - ADDR_W'(OFF_SRC_BASE);
    assign aff_hit = (bus_addr >= ADDR_W'(OFF_SRC_BASE)) && (aoff[1:0] == 2'b00)
                     && (aoff[ADDR_W-1:2] < (ADDR_W-2)'(N_SRC));
    assign aidx    = aoff[SRC_W+1:2];
    // Source numbers at or beyond N_SRC are rejected.
    assign val_ok  = bus_wdata < DATA_W'(N_SRC);

    // Write decode: pick the operation and the source it targets.
    always_comb begin
        wr_op  = OP_NONE;
        wr_idx = bus_wdata[SRC_W-1:0];
        if (bus_valid && bus_write) begin
            if (aff_hit) begin
                wr_op  = OP_AFF_WR;
                wr_idx = aidx;
            end else if (val_ok) begin
                case (bus_addr)
                    ADDR_W'(OFF_EN_SET):  wr_op = OP_EN_SET;
                    ADDR_W'(OFF_EN_CLR):  wr_op = OP_EN_CLR;
                    ADDR_W'(OFF_MSK_SET): wr_op = OP_MSK_SET;
                    ADDR_W'(OFF_MSK_CLR): wr_op = OP_MSK_CLR;
                    default:              wr_op = OP_NONE;
                endcase
            end
        end
    end

    // Read decode: choose which view the read returns.
    always_comb begin
        rd_sel = RS_ZERO;
        rd_idx = aidx;
        if (aff_hit) begin
            rd_sel = RS_AFF;
        end else begin
            case (bus_addr)
                ADDR_W'(OFF_CTRL):    rd_sel = RS_GEN;
                ADDR_W'(OFF_RAW):     rd_sel = RS_RAW;
                ADDR_W'(OFF_MSK_SET),
                ADDR_W'(OFF_MSK_CLR): rd_sel = RS_PEND;
                default:              rd_sel = RS_ZERO;
            endcase
        end
    end

endmodule

// File: rtl/dig_global_en.sv
// Shared first gate: one enable bit per source, changed one bit at a time
// by set/clear operations. Cleared by reset.
module dig_global_en
    import dig_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  dig_op_e                   wr_op,
    input  logic [$clog2(N_SRC)-1:0]  wr_idx,
    output logic [N_SRC-1:0]          gen_en
);
    // Apply a single-bit set or clear of the global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en <= '0;
        end else begin
            case (wr_op)
                OP_EN_SET: gen_en[wr_idx] <= 1'b1;
                OP_EN_CLR: gen_en[wr_idx] <= 1'b0;
                default:   ;
            endcase
        end
    end

endmodule

// File: rtl/dig_cpu_mask.sv
// Second gate for one CPU: an unmask bit per source (1 = passes). Aliased
// mask operations act only when the accessing CPU matches CPU_ID; an
// affinity write loads this bank's bit regardless of who wrote it.
// Reset leaves every source masked.
module dig_cpu_mask
    import dig_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_CPU  = 2,
    parameter int CPU_ID = 0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  dig_op_e                   wr_op,
    input  logic [$clog2(N_SRC)-1:0]  wr_idx,
    input  logic [$clog2(N_CPU)-1:0]  acc_cpu,
    input  logic                      aff_bit,
    output logic [N_SRC-1:0]          unmask
);
    localparam int CPU_W = $clog2(N_CPU);

    logic own;

    // Aliased window hits this bank only for its own CPU.
    assign own = (acc_cpu == CPU_W'(CPU_ID));

    // Update one unmask bit from the aliased window or an affinity write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unmask <= '0;
        end else begin
            case (wr_op)
                OP_MSK_SET: if (own) unmask[wr_idx] <= 1'b0;
                OP_MSK_CLR: if (own) unmask[wr_idx] <= 1'b1;
                OP_AFF_WR:  unmask[wr_idx] <= aff_bit;
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/dig_out_stage.sv
// Output stage: per CPU, OR-reduce (input & enable & unmask) and register
// the result for one clock. Inputs are treated as levels.
module dig_out_stage #(
    parameter int N_SRC = 32,
    parameter int N_CPU = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_SRC-1:0]            irq_in,
    input  logic [N_SRC-1:0]            gen_en,
    input  logic [N_CPU-1:0][N_SRC-1:0] unmask,
    output logic [N_CPU-1:0]            cpu_irq
);
    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        // Register the gated OR for CPU c.
        always_ff @(posedge clk) begin
            if (!rst_n) cpu_irq[c] <= 1'b0;
            else        cpu_irq[c] <= |(irq_in & gen_en & unmask[c]);
        end
    end

endmodule

// File: rtl/dual_irq_gate.sv
// Top: two-stage interrupt gating for N_CPU CPUs behind a register bus with
// a CPU-ID sideband. Holds the decoder, the shared enable stage, one mask
// bank per CPU and the registered output and read paths. Assumes one bus
// beat per request and N_SRC <= DATA_W.
module dual_irq_gate
    import dig_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_CPU  = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          irq_in,
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [$clog2(N_CPU)-1:0]  bus_cpu,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic                      bus_rvalid,
    output logic [N_CPU-1:0]          cpu_irq
);
    localparam int SRC_W = $clog2(N_SRC);

    dig_op_e                    wr_op;
    dig_rsel_e                  rd_sel;
    logic [SRC_W-1:0]           wr_idx;
    logic [SRC_W-1:0]           rd_idx;
    logic [N_SRC-1:0]           gen_en;
    logic [N_CPU-1:0][N_SRC-1:0] unmask;
    logic [DATA_W-1:0]          rd_next;

    dig_decode #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_op     (wr_op),
        .wr_idx    (wr_idx),
        .rd_sel    (rd_sel),
        .rd_idx    (rd_idx)
    );

    dig_global_en #(.N_SRC(N_SRC)) u_gen (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_op  (wr_op),
        .wr_idx (wr_idx),
        .gen_en (gen_en)
    );

    for (genvar c = 0; c < N_CPU; c++) begin : g_bank
        dig_cpu_mask #(.N_SRC(N_SRC), .N_CPU(N_CPU), .CPU_ID(c)) u_msk (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_op   (wr_op),
            .wr_idx  (wr_idx),
            .acc_cpu (bus_cpu),
            .aff_bit (bus_wdata[c]),
            .unmask  (unmask[c])
        );
    end

    dig_out_stage #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .gen_en  (gen_en),
        .unmask  (unmask),
        .cpu_irq (cpu_irq)
    );

    // Select the read view for the current request.
    always_comb begin
        rd_next = '0;
        case (rd_sel)
            RS_GEN:  rd_next[N_SRC-1:0] = gen_en;
            RS_RAW:  rd_next[N_SRC-1:0] = irq_in;
            RS_PEND: rd_next[N_SRC-1:0] = irq_in & gen_en & unmask[bus_cpu];
            RS_AFF:  for (int c = 0; c < N_CPU; c++) rd_next[c] = unmask[c][rd_idx];
            default: rd_next = '0;
        endcase
    end

    // Register the read response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write) bus_rdata <= rd_next;
        end
    end

endmodule

// File: rtl/dig_checker.sv
// Property checker for dual_irq_gate, attached through bind. Observes ports
// and the enable/mask state held by separate submodules.
module dig_checker
    import dig_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_CPU  = 2,
    parameter int ADDR_W = 8
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [N_SRC-1:0]            irq_in,
    input logic                        bus_valid,
    input logic                        bus_write,
    input logic [$clog2(N_CPU)-1:0]    bus_cpu,
    input logic [ADDR_W-1:0]           bus_addr,
    input logic                        bus_rvalid,
    input logic [N_SRC-1:0]            gen_en,
    input logic [N_CPU-1:0][N_SRC-1:0] unmask,
    input logic [N_CPU-1:0]            cpu_irq
);
    localparam int CPU_W = $clog2(N_CPU);

    logic past_ok = 1'b0;

    // Marks cycles whose previous edge was already out of reset.
    always_ff @(posedge clk) past_ok <= rst_n;

    // R2: reset clears enables, masks every source and drops the outputs.
    a_r2_reset_state: assert property (@(posedge clk)
        !rst_n |=> (gen_en == '0 && unmask == '0 && cpu_irq == '0));

    // R3: one bus beat changes at most one global enable bit.
    a_r3_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> $countones(gen_en ^ $past(gen_en)) <= 1);

    // R8: every read gets exactly one response in the next cycle.
    a_r8_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> !bus_rvalid);

    for (genvar c = 0; c < N_CPU; c++) begin : g_chk
        // R1: output is the registered two-stage gated OR.
        a_r1_gated_or: assert property (@(posedge clk) disable iff (!rst_n)
            past_ok |-> cpu_irq[c] == $past(|(irq_in & gen_en & unmask[c])));

        // R4: the aliased window never touches another CPU's bank.
        a_r4_bank_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && bus_write && bus_cpu != CPU_W'(c) &&
             (bus_addr == ADDR_W'(OFF_MSK_SET) || bus_addr == ADDR_W'(OFF_MSK_CLR)))
            |=> $stable(unmask[c]));
    end

endmodule

bind dual_irq_gate dig_checker #(
    .N_SRC  (N_SRC),
    .N_CPU  (N_CPU),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_cpu    (bus_cpu),
    .bus_addr   (bus_addr),
    .bus_rvalid (bus_rvalid),
    .gen_en     (gen_en),
    .unmask     (unmask),
    .cpu_irq    (cpu_irq)
);

// File: tb/dual_irq_gate_tb_top.sv
`timescale 1ns/1ps
// Bench for dual_irq_gate: directed corner cases followed by seeded random
// operations, all compared against a bench-side model of enables and masks.
module dual_irq_gate_tb_top;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [0:0]  bus_cpu = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [1:0]  cpu_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0]      m_gen = '0;
    logic [1:0][31:0] m_um  = '0;

    always #2 clk = ~clk;

    dual_irq_gate dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cpu_irq(cpu_irq)
    );

    function automatic logic [31:0] pend(int c);
        return irq_in & m_gen & m_um[c];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(int cpu, logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 1'(cpu);
        bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic read_chk(string req, int cpu, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 1'(cpu); bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R8 rvalid", {31'b0, bus_rvalid}, 32'd1);
        check(req, bus_rdata, exp);
    endtask

    // R1: both outputs after one more edge, inputs held.
    task automatic out_chk(string req);
        @(posedge clk);
        @(negedge clk);
        check(req, {30'b0, cpu_irq}, {30'b0, |pend(1), |pend(0)});
    endtask

    // Model-updating operations.
    task automatic en_set(int cpu, logic [31:0] v);
        bus_wr(cpu, 8'h08, v);
        if (v < NS) m_gen[v[4:0]] = 1'b1;
    endtask
    task automatic en_clr(int cpu, logic [31:0] v);
        bus_wr(cpu, 8'h0C, v);
        if (v < NS) m_gen[v[4:0]] = 1'b0;
    endtask
    task automatic msk_set(int cpu, logic [31:0] v);
        bus_wr(cpu, 8'h40, v);
        if (v < NS) m_um[cpu][v[4:0]] = 1'b0;
    endtask
    task automatic msk_clr(int cpu, logic [31:0] v);
        bus_wr(cpu, 8'h44, v);
        if (v < NS) m_um[cpu][v[4:0]] = 1'b1;
    endtask
    task automatic aff_wr(int cpu, int src, logic [31:0] v);
        bus_wr(cpu, 8'(8'h80 + 4 * src), v);
        m_um[0][src] = v[0];
        m_um[1][src] = v[1];
    endtask

    initial begin
        void'($urandom(32'h5EED_0A17));
        irq_in = '1;
        repeat (5) @(negedge clk);
        // R2: outputs low and response strobe idle under reset.
        check("R2 cpu_irq in reset", {30'b0, cpu_irq}, 32'd0);
        check("R2 rvalid in reset", {31'b0, bus_rvalid}, 32'd0);
        rst_n = 1'b1;
        out_chk("R2 R1 masked after reset");
        read_chk("R2 R6 enables zero", 0, 8'h00, 32'd0);
        read_chk("R2 R7 pending zero", 1, 8'h40, 32'd0);
        read_chk("R2 R5 affinity zero", 0, 8'h80 + 8'd20, 32'd0);

        // R3: enable alone does not reach a masked CPU.
        irq_in = 32'h8;
        en_set(0, 3);
        out_chk("R1 enabled but masked");
        read_chk("R3 enable bit 3", 1, 8'h00, 32'h8);
        // R5: affinity to CPU0 only.
        aff_wr(1, 3, 32'h1);
        out_chk("R5 R1 affinity cpu0");
        read_chk("R5 affinity read", 0, 8'h8C, 32'h1);
        // R4: CPU1 unmasks via the aliased window.
        msk_clr(1, 3);
        out_chk("R4 unmask cpu1");
        read_chk("R7 pending cpu0", 0, 8'h40, 32'h8);
        read_chk("R7 pending cpu1", 1, 8'h44, 32'h8);
        // R4: CPU0 masks; CPU1 bank untouched.
        msk_set(0, 3);
        out_chk("R4 mask cpu0 only");
        read_chk("R4 R5 affinity after mask", 1, 8'h8C, 32'h2);
        read_chk("R7 pending cpu0 masked", 0, 8'h40, 32'h0);
        // R3 R4: out-of-range source numbers are ignored.
        en_set(0, 32);
        en_set(1, 35);
        msk_clr(0, 32'h0000_0103);
        read_chk("R3 out-of-range enable", 0, 8'h00, 32'h8);
        read_chk("R4 out-of-range mask", 0, 8'h8C, 32'h2);
        // R8: writes to read-only / unmapped offsets are ignored.
        bus_wr(0, 8'h00, 32'hFFFF_FFFF);
        bus_wr(1, 8'h20, 32'hFFFF_FFFF);
        bus_wr(0, 8'h82, 32'h3);
        read_chk("R8 ro write ignored", 1, 8'h00, 32'h8);
        read_chk("R8 misaligned ignored", 0, 8'h80, 32'h0);
        read_chk("R8 unmapped read", 0, 8'h20, 32'h0);
        // R6: raw input view.
        irq_in = 32'hA5A5_0F0F;
        read_chk("R6 raw inputs", 1, 8'h04, 32'hA5A5_0F0F);
        // R1: level input drops, output follows.
        irq_in = 32'h8;
        out_chk("R1 level high");
        irq_in = 32'h0;
        out_chk("R1 level drop");
        // R3: clear enable blocks an unmasked active source.
        irq_in = 32'h8;
        en_clr(1, 3);
        out_chk("R3 cleared enable");
        // R3: set/clear touches only one bit.
        en_set(0, 0);
        en_set(0, 31);
        en_clr(1, 0);
        read_chk("R3 single-bit update", 0, 8'h00, 32'h8000_0000);

        // Random mix.
        for (int i = 0; i < 600; i++) begin
            int op;
            int cpu;
            logic [31:0] v;
            op  = int'($urandom % 7);
            cpu = int'($urandom % 2);
            v   = ($urandom % 4 == 0) ? ($urandom % 40) : ($urandom % 32);
            case (op)
                0: en_set(cpu, v);
                1: en_clr(cpu, v);
                2: msk_set(cpu, v);
                3: msk_clr(cpu, v);
                4: aff_wr(cpu, int'($urandom % 32), $urandom);
                5: read_chk("R7 random pending", cpu, 8'h40 + 8'(4 * ($urandom % 2)), pend(cpu));
                default: begin
                    int s;
                    s = int'($urandom % 32);
                    read_chk("R5 random affinity", cpu, 8'(8'h80 + 4 * s), {30'b0, m_um[1][s], m_um[0][s]});
                end
            endcase
            irq_in = $urandom;
            out_chk("R1 random outputs");
            if (i % 50 == 0) read_chk("R6 random enables", cpu, 8'h00, m_gen);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule